// File: doc/BRIEF.md
# AC97 Frame Payload Scheduler

This block fills the data slots of every outgoing AC97 frame and spreads the data slots of every incoming frame. Two masks choose the active slots among slots 3 to 12. One mask is for the transmit direction and one is for the receive direction. A link layer, outside this block, asks for an outgoing payload with `frame_start` and collects the result when `frame_done` pulses. The link layer also hands over each decoded incoming frame with `rx_frame_stb`.

The transmit side follows the codec's on-demand slot requests. These are read from slot 1 of each accepted incoming frame, and a bit value of zero means the slot is requested. A frame carries data only when all of the following hold: every enabled transmit slot is requested, the mask is not empty, and the transmit FIFO holds enough words for all enabled slots. In every other case the frame goes out empty. An empty frame consumes no FIFO word, so the word order in the FIFO never shifts.

The transmit controller has three states:
- `TX_IDLE` moves to `TX_FILL` on a start that can be honoured ("fill"). On any other start it moves to `TX_EMIT` ("skip").
- `TX_FILL` walks the ten slots and moves to `TX_EMIT` after the last one ("filled").
- `TX_EMIT` pulses `frame_done` and returns to `TX_IDLE` ("release").

The receive distributor has two states:
- `RX_IDLE` moves to `RX_PUSH` when it accepts a frame ("capture").
- `RX_PUSH` offers one slot per cycle and returns to `RX_IDLE` after the last slot ("drain").

Top module: `ac97_frame_sched`

## Requirements
- R1: After reset, every slot counts as not requested, so a transmit frame started before any incoming frame is accepted is empty. `frame_done`, `txf_ready` and `rxf_valid` are low out of reset.
- R2: A full frame pops exactly as many FIFO words as there are enabled transmit slots. The words are placed in ascending slot order, and slot s lands at `frame_slots[(s-3)*20 +: 20]`. Slots that are not enabled read zero.
- R3: The tag of a full frame has bit 15 set and bit 15-s set for each slot s that carries data. All other tag bits are zero.
- R4: If any enabled transmit slot has its request bit at one, the frame is empty: tag zero, all slots zero, no pop, and no underrun.
- R5: If `txf_count` is smaller than the number of enabled slots, and every enabled slot is requested, the frame is empty with no pop. `tx_underrun` is high during its `frame_done` cycle.
- R6: The request bit for slot s is bit 14-s of `rx_slot1`. It is captured when an incoming frame is accepted and holds for all later transmit frames until the next capture. Request bits of slots that are not enabled have no effect.
- R7: Each slot s that is enabled in `rx_slot_en` is pushed to the RX FIFO in ascending slot order, if the incoming tag has bit 15 set and bit 15-s set. No other slot is pushed. For example, slots 9 to 12 give four pushes per frame.
- R8: A push offered while `rxf_ready` is low is dropped, and `rx_overflow` is high in that cycle.
- R9: `frame_start` while a transmit frame is in progress is ignored, and so is `rx_frame_stb` while a receive frame is being drained. `frame_done` lasts one cycle per accepted start.
- R10: An all-zero transmit mask yields an empty frame with no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_slot_en | input | 10 | Transmit slot mask, bit i is slot i+3 |
| rx_slot_en | input | 10 | Receive slot mask, bit i is slot i+3 |
| frame_start | input | 1 | Request to build the next outgoing payload |
| txf_count | input | 5 | Words currently held by the TX FIFO |
| txf_valid | input | 1 | TX FIFO head word valid |
| txf_data | input | 20 | TX FIFO head word |
| txf_ready | output | 1 | Pop of the TX FIFO head |
| frame_done | output | 1 | Outgoing payload ready, one-cycle pulse |
| frame_tag | output | 16 | Outgoing slot 0 tag |
| frame_slots | output | 200 | Outgoing slots 3..12, 20 bits each |
| tx_underrun | output | 1 | Frame emptied for lack of FIFO words |
| rx_frame_stb | input | 1 | Incoming frame available |
| rx_tag | input | 16 | Incoming slot 0 tag |
| rx_slot1 | input | 20 | Incoming slot 1 (request bits) |
| rx_slots | input | 200 | Incoming slots 3..12, 20 bits each |
| rxf_valid | output | 1 | RX FIFO push |
| rxf_data | output | 20 | RX FIFO push data |
| rxf_ready | input | 1 | RX FIFO can accept |
| rx_overflow | output | 1 | Push dropped on a full RX FIFO |

## Verification
If the captured request state is wrong, the fault shows up in the very next `frame_done`. It appears as an empty tag where a full one is due, or as a full tag where an empty one is due. A slot walk that goes wrong shows at once as a pop count that differs from the mask population, or as words sitting in the wrong slot field. Popping a word on an empty frame is also visible right away. It shifts every later payload, so the vector walk, which checks slot contents after each frame, catches it by the next full frame at the latest. On the receive side, a wrong mask or tag decode changes the number and order of pushes within ten cycles of the strobe.

// File: rtl/ac97_sched_pkg.sv
package ac97_sched_pkg;

    localparam int TAG_W      = 16;
    localparam int FIRST_SLOT = 3;
    // tag bit of the first data slot (bit 15 - slot)
    localparam int TAG_TOP    = TAG_W - 1 - FIRST_SLOT;
    // slot-1 request bit of the first data slot (bit 14 - slot)
    localparam int REQ_TOP    = 14 - FIRST_SLOT;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_FILL = 2'd1,
        TX_EMIT = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_PUSH = 1'b1
    } rx_state_e;

endpackage

// File: rtl/ac97_tx_sched.sv
module ac97_tx_sched
    import ac97_sched_pkg::*;
#(
    parameter int DW    = 20,
    parameter int NSLOT = 10,
    parameter int CNT_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSLOT-1:0]       slot_en,
    input  logic                   start,
    input  logic [NSLOT-1:0]       req_n,
    input  logic [CNT_W-1:0]       txf_count,
    input  logic                   txf_valid,
    input  logic [DW-1:0]          txf_data,
    output logic                   txf_ready,
    output logic                   done,
    output logic [TAG_W-1:0]       tag,
    output logic [NSLOT*DW-1:0]    slots,
    output logic                   underrun
);

    localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam logic [IW-1:0] LAST = IW'(NSLOT - 1);

    function automatic logic [CNT_W-1:0] count_set(input logic [NSLOT-1:0] m);
        count_set = '0;
        for (int i = 0; i < NSLOT; i++) count_set = count_set + CNT_W'(m[i]);
    endfunction

    function automatic logic [TAG_W-1:0] mask_to_tag(input logic [NSLOT-1:0] m);
        mask_to_tag = '0;
        mask_to_tag[TAG_W-1] = 1'b1;
        for (int i = 0; i < NSLOT; i++) mask_to_tag[TAG_TOP-i] = m[i];
    endfunction

    tx_state_e            state_q, state_d;
    logic [IW-1:0]        idx_q;
    logic [NSLOT-1:0]     en_q;
    logic [TAG_W-1:0]     tag_q;
    logic [NSLOT*DW-1:0]  slots_q;
    logic                 und_q;

    logic all_req, enough, go_fill, go_under, advance;

    assign all_req  = (slot_en & req_n) == '0;
    assign enough   = txf_count >= count_set(slot_en);
    assign go_fill  = (slot_en != '0) && all_req && enough;
    assign go_under = (slot_en != '0) && all_req && !enough;
    assign advance  = !en_q[idx_q] || txf_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // transitions: fill, skip, filled, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (start) state_d = go_fill ? TX_FILL : TX_EMIT;
            TX_FILL: if (advance && idx_q == LAST) state_d = TX_EMIT;
            TX_EMIT: state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        txf_ready = (state_q == TX_FILL) && en_q[idx_q] && txf_valid;
        done      = (state_q == TX_EMIT);
        underrun  = (state_q == TX_EMIT) && und_q;
        tag       = tag_q;
        slots     = slots_q;
    end

    // payload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            en_q    <= '0;
            tag_q   <= '0;
            slots_q <= '0;
            und_q   <= 1'b0;
        end else if (state_q == TX_IDLE && start) begin
            idx_q   <= '0;
            en_q    <= slot_en;
            tag_q   <= '0;
            slots_q <= '0;
            und_q   <= go_under;
        end else if (state_q == TX_FILL) begin
            if (txf_ready) begin
                slots_q[idx_q*DW +: DW] <= txf_data;
                tag_q[TAG_W-1]          <= 1'b1;
                tag_q[TAG_TOP-int'(idx_q)] <= 1'b1;
            end
            if (advance && idx_q != LAST) idx_q <= idx_q + 1'b1;
        end
    end

    // pop tally, used by the checks below
    logic [CNT_W-1:0] pops_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          pops_q <= '0;
        else if (state_q == TX_IDLE && start) pops_q <= '0;
        else if (txf_ready)                  pops_q <= pops_q + 1'b1;
    end

    AST_POP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pops_q == (tag[TAG_W-1] ? count_set(en_q) : '0)); // R2
    AST_FULL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tag[TAG_W-1]) |-> tag == mask_to_tag(en_q)); // R3
    AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !tag[TAG_W-1]) |-> (tag == '0 && slots == '0)); // R4
    AST_UNDERRUN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (tag == '0 && pops_q == '0)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

endmodule

// File: rtl/ac97_rx_dist.sv
module ac97_rx_dist
    import ac97_sched_pkg::*;
#(
    parameter int DW    = 20,
    parameter int NSLOT = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSLOT-1:0]       slot_en,
    input  logic                   frame_stb,
    input  logic [TAG_W-1:0]       tag,
    input  logic [DW-1:0]          slot1,
    input  logic [NSLOT*DW-1:0]    slots,
    output logic [NSLOT-1:0]       req_n,
    output logic                   rxf_valid,
    output logic [DW-1:0]          rxf_data,
    input  logic                   rxf_ready,
    output logic                   overflow
);

    localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam logic [IW-1:0] LAST = IW'(NSLOT - 1);

    rx_state_e            state_q, state_d;
    logic [IW-1:0]        idx_q;
    logic [NSLOT-1:0]     mask_q;
    logic [NSLOT-1:0]     req_q;
    logic [NSLOT*DW-1:0]  data_q;
    logic [NSLOT-1:0]     tag_slots;
    logic [NSLOT-1:0]     req_field;
    logic                 unused_bits;

    assign unused_bits = ^{slot1, tag};

    for (genvar g = 0; g < NSLOT; g++) begin : g_map
        assign tag_slots[g] = tag[TAG_TOP-g];
        assign req_field[g] = slot1[REQ_TOP-g];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions: capture, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (frame_stb) state_d = RX_PUSH;
            RX_PUSH: if (idx_q == LAST) state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rxf_valid = (state_q == RX_PUSH) && mask_q[idx_q];
        rxf_data  = data_q[idx_q*DW +: DW];
        overflow  = rxf_valid && !rxf_ready;
        req_n     = req_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mask_q <= '0;
            req_q  <= '1;
            data_q <= '0;
        end else if (state_q == RX_IDLE && frame_stb) begin
            idx_q  <= '0;
            mask_q <= tag[TAG_W-1] ? (slot_en & tag_slots) : '0;
            req_q  <= req_field;
            data_q <= slots;
        end else if (state_q == RX_PUSH && idx_q != LAST) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(req_n)); // R6
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_PUSH && frame_stb) |=> ($stable(req_n) && $stable(data_q))); // R9

endmodule

// File: rtl/ac97_frame_sched.sv
module ac97_frame_sched
    import ac97_sched_pkg::*;
#(
    parameter int DW    = 20,
    parameter int NSLOT = 10,
    parameter int CNT_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSLOT-1:0]       tx_slot_en,
    input  logic [NSLOT-1:0]       rx_slot_en,
    input  logic                   frame_start,
    input  logic [CNT_W-1:0]       txf_count,
    input  logic                   txf_valid,
    input  logic [DW-1:0]          txf_data,
    output logic                   txf_ready,
    output logic                   frame_done,
    output logic [TAG_W-1:0]       frame_tag,
    output logic [NSLOT*DW-1:0]    frame_slots,
    output logic                   tx_underrun,
    input  logic                   rx_frame_stb,
    input  logic [TAG_W-1:0]       rx_tag,
    input  logic [DW-1:0]          rx_slot1,
    input  logic [NSLOT*DW-1:0]    rx_slots,
    output logic                   rxf_valid,
    output logic [DW-1:0]          rxf_data,
    input  logic                   rxf_ready,
    output logic                   rx_overflow
);

    logic [NSLOT-1:0] req_n;

    ac97_tx_sched #(.DW(DW), .NSLOT(NSLOT), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (tx_slot_en),
        .start     (frame_start),
        .req_n     (req_n),
        .txf_count (txf_count),
        .txf_valid (txf_valid),
        .txf_data  (txf_data),
        .txf_ready (txf_ready),
        .done      (frame_done),
        .tag       (frame_tag),
        .slots     (frame_slots),
        .underrun  (tx_underrun)
    );

    ac97_rx_dist #(.DW(DW), .NSLOT(NSLOT)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (rx_slot_en),
        .frame_stb (rx_frame_stb),
        .tag       (rx_tag),
        .slot1     (rx_slot1),
        .slots     (rx_slots),
        .req_n     (req_n),
        .rxf_valid (rxf_valid),
        .rxf_data  (rxf_data),
        .rxf_ready (rxf_ready),
        .overflow  (rx_overflow)
    );

endmodule

// File: tb/tb_ac97_frame_sched.sv
module tb_ac97_frame_sched;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [9:0]  en;
        logic [19:0] s1;
        logic [4:0]  avail;
        logic [15:0] tag;
        logic [4:0]  pops;
        logic        und;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{10'h003, 20'h00000, 5'd5,  16'h9800, 5'd2,  1'b0},  // R2 R3 slots 3,4
        '{10'h003, 20'h00400, 5'd5,  16'h0000, 5'd0,  1'b0},  // R4 slot 4 not requested
        '{10'h003, 20'h003FC, 5'd5,  16'h9800, 5'd2,  1'b0},  // R6 others ignored
        '{10'h003, 20'h00000, 5'd1,  16'h0000, 5'd0,  1'b1},  // R5 underrun
        '{10'h3FF, 20'h00000, 5'd10, 16'h9FF8, 5'd10, 1'b0},  // R2 all slots
        '{10'h000, 20'h00000, 5'd3,  16'h0000, 5'd0,  1'b0},  // R10 empty mask
        '{10'h248, 20'h00000, 5'd3,  16'h8248, 5'd3,  1'b0},  // R3 slots 6,9,12
        '{10'h3FF, 20'h00000, 5'd9,  16'h0000, 5'd0,  1'b1},  // R5 one short
        '{10'h248, 20'h00200, 5'd3,  16'h8248, 5'd3,  1'b0}   // R6 slot 5 off mask
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [9:0]   tx_slot_en = '0, rx_slot_en = '0;
    logic         frame_start = 1'b0;
    logic [4:0]   txf_count;
    logic         txf_valid;
    logic [19:0]  txf_data;
    logic         txf_ready, frame_done, tx_underrun;
    logic [15:0]  frame_tag;
    logic [199:0] frame_slots;
    logic         rx_frame_stb = 1'b0;
    logic [15:0]  rx_tag = '0;
    logic [19:0]  rx_slot1 = '0;
    logic [199:0] rx_slots = '0;
    logic         rxf_valid, rx_overflow;
    logic [19:0]  rxf_data;
    logic         rxf_ready = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ac97_frame_sched dut (.*);

    // bench TX FIFO: write pointer owned by the stimulus, read pointer by the monitor
    logic [19:0] fmem [16];
    int fwr = 0, frd = 0;
    assign txf_valid = frd < fwr;
    assign txf_data  = fmem[frd % 16];
    assign txf_count = 5'(fwr - frd);

    int pops = 0, dones = 0, pushes = 0, ovfs = 0, cyc = 0;
    logic [19:0] pushed [64];
    int errors = 0, checks = 0;
    bit finished = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (txf_valid && txf_ready) begin frd <= frd + 1; pops <= pops + 1; end
        if (frame_done) dones <= dones + 1;
        if (rxf_valid && rxf_ready) begin pushed[pushes % 64] <= rxf_data; pushes <= pushes + 1; end
        if (rx_overflow) ovfs <= ovfs + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_fifo(input int n, input logic [19:0] base);
        fwr = frd;
        for (int k = 0; k < n; k++) fmem[(fwr + k) % 16] = base + 20'(k);
        fwr = fwr + n;
    endtask

    task automatic send_rx(input logic [15:0] t, input logic [19:0] s1, input logic [19:0] base);
        rx_tag = t; rx_slot1 = s1;
        for (int i = 0; i < 10; i++) rx_slots[i*20 +: 20] = base + 20'(i + 3);
        rx_frame_stb = 1'b1;
        tick(1);
        rx_frame_stb = 1'b0;
        tick(12);
    endtask

    task automatic start_wait(output bit got);
        int w;
        frame_start = 1'b1;
        tick(1);
        frame_start = 1'b0;
        w = 0;
        while (!frame_done && w < 40) begin tick(1); w++; end
        got = frame_done;
        if (!got) chk(1'b0, "R9", "frame_done timeout", 0, 1);
    endtask

    initial begin
        bit got;
        int p0, d0, q0, o0, ord;
        logic [19:0] exp_w;

        tick(3);
        chk(!frame_done && !txf_ready && !rxf_valid, "R1", "outputs in reset",
            {frame_done, txf_ready, rxf_valid}, 0);
        rst_n = 1'b1;
        tick(2);

        // R1: no request captured yet, frame must be empty
        tx_slot_en = 10'h003;
        load_fifo(5, 20'h10000);
        p0 = pops;
        start_wait(got);
        chk(frame_tag == 16'h0, "R1", "tag before any request", frame_tag, 0);
        tick(1);
        chk(pops == p0, "R1", "pops before any request", pops - p0, 0);

        // vector walk
        for (int v = 0; v < NV; v++) begin
            tx_slot_en = VECS[v].en;
            send_rx(16'h0, VECS[v].s1, 20'h0);
            load_fifo(int'(VECS[v].avail), 20'h20000 + 20'(v * 256));
            p0 = pops;
            start_wait(got);
            chk(frame_tag == VECS[v].tag, "R3", $sformatf("vec %0d tag", v), frame_tag, VECS[v].tag);
            chk(tx_underrun == VECS[v].und, "R5", $sformatf("vec %0d underrun", v), tx_underrun, VECS[v].und);
            ord = 0;
            for (int i = 0; i < 10; i++) begin
                if (VECS[v].tag[15] && VECS[v].en[i]) begin
                    exp_w = 20'h20000 + 20'(v * 256) + 20'(ord);
                    ord++;
                end else exp_w = '0;
                chk(frame_slots[i*20 +: 20] == exp_w, "R2", $sformatf("vec %0d slot %0d", v, i + 3),
                    frame_slots[i*20 +: 20], exp_w);
            end
            tick(1);
            chk(pops - p0 == int'(VECS[v].pops), "R4", $sformatf("vec %0d pops", v), pops - p0, VECS[v].pops);
        end

        // R9: second start during fill is ignored
        tx_slot_en = 10'h003;
        send_rx(16'h0, 20'h0, 20'h0);
        load_fifo(5, 20'h30000);
        p0 = pops; d0 = dones;
        frame_start = 1'b1; tick(1); frame_start = 1'b0;
        tick(2);
        frame_start = 1'b1; tick(1); frame_start = 1'b0;
        tick(30);
        chk(dones - d0 == 1, "R9", "done pulses", dones - d0, 1);
        chk(pops - p0 == 2, "R9", "pops with extra start", pops - p0, 2);

        // R7: slots 9..12 all tagged
        rx_slot_en = 10'h3C0;
        q0 = pushes;
        send_rx(16'h9FF8, 20'h0, 20'hA0000);
        chk(pushes - q0 == 4, "R7", "push count 9..12", pushes - q0, 4);
        for (int k = 0; k < 4; k++)
            chk(pushed[(q0 + k) % 64] == 20'hA0000 + 20'(9 + k), "R7", $sformatf("push %0d data", k),
                pushed[(q0 + k) % 64], 20'hA0000 + 20'(9 + k));

        // R7: slot 10 not tagged
        q0 = pushes;
        send_rx(16'h9FD8, 20'h0, 20'hA0000);
        chk(pushes - q0 == 3, "R7", "push count without slot 10", pushes - q0, 3);
        chk(pushed[(q0 + 1) % 64] == 20'hA000B, "R7", "second push is slot 11", pushed[(q0 + 1) % 64], 20'hA000B);

        // R7: frame valid bit clear
        q0 = pushes;
        send_rx(16'h1FF8, 20'h0, 20'hA0000);
        chk(pushes - q0 == 0, "R7", "push count invalid frame", pushes - q0, 0);

        // R8: full RX FIFO
        rxf_ready = 1'b0;
        q0 = pushes; o0 = ovfs;
        send_rx(16'h9FF8, 20'h0, 20'hA0000);
        chk(ovfs - o0 == 4, "R8", "overflow cycles", ovfs - o0, 4);
        chk(pushes - q0 == 0, "R8", "accepted pushes", pushes - q0, 0);
        rxf_ready = 1'b1;

        // R9: strobe during drain ignored
        q0 = pushes;
        rx_tag = 16'h9FF8;
        for (int i = 0; i < 10; i++) rx_slots[i*20 +: 20] = 20'hA0000 + 20'(i + 3);
        rx_frame_stb = 1'b1; tick(1); rx_frame_stb = 1'b0;
        tick(2);
        for (int i = 0; i < 10; i++) rx_slots[i*20 +: 20] = 20'hB0000 + 20'(i + 3);
        rx_frame_stb = 1'b1; tick(1); rx_frame_stb = 1'b0;
        tick(15);
        chk(pushes - q0 == 4, "R9", "pushes with extra strobe", pushes - q0, 4);
        chk(pushed[(q0 + 3) % 64] == 20'hA000C, "R9", "last push from first frame", pushed[(q0 + 3) % 64], 20'hA000C);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule